// File: doc/BRIEF.md
# UART Interrupt Identification Encoder

This block gathers every interrupt condition of a single-channel serial port and turns them into the byte that software reads to learn why it was interrupted, together with an active-high interrupt request. Level conditions (line error, receive data ready, receive timeout, modem status change, flow-control line change) are taken as they stand. Two event conditions are remembered in flags: transmit-holding-empty and Xoff/special-character detection.

Each source is reported only when its own enable bit is set. The highest-priority enabled source is encoded into the low six bits, and bit 0 is low whenever anything is pending. The two extended sources, Xoff/special character and flow-line change, can only be reported while the extended-feature enable is high. Reading the register while transmit-empty is the reported cause acknowledges that cause. The Xoff flag stays set until an Xon detection clears it.

Top module: `uart_irq_id`

## Requirements
- R1: After reset every stored flag is clear: with fifo_en low and no level source active, iir reads 0x01 and irq is 0.
- R2: Bit 0 of iir is 0 exactly when some enabled source is pending, and irq is always the inverse of iir bit 0.
- R3: The low six bits identify the reported source: line error 000110, receive timeout 001100, receive ready 000100, transmit empty 000010, modem status 000000, Xoff/special 010000, flow-line change 100000. With no source pending they read 000001.
- R4: Priority from highest to lowest is line error, receive timeout, receive ready, transmit empty, modem status, Xoff/special, flow-line change. When receive timeout and receive ready are both active, the timeout is reported.
- R5: Enable bit positions in ier are: bit 0 receive ready and timeout, bit 1 transmit empty, bit 2 line error, bit 3 modem status, bit 4 Xoff/special, bit 5 flow-line change. A source whose enable bit is 0 is not reported, but its stored flag is kept and appears once the bit is set.
- R6: The Xoff/special and flow-line change sources are reported only while efr_en is 1. While efr_en is 0, iir bits 5:4 read 0.
- R7: A one-cycle xoff_det pulse sets a sticky flag that is visible from the next cycle. The flag holds until an xon_det pulse clears it. When xoff_det and xon_det arrive in the same cycle, the flag ends up set.
- R8: A thr_evt pulse sets the transmit-empty flag, visible from the next cycle. An iir_rd pulse while transmit-empty is the reported source clears the flag from the next cycle.
- R9: When iir_rd and thr_evt fall in the same cycle while transmit-empty is reported, the flag stays set.
- R10: An iir_rd pulse while another source is reported leaves the transmit-empty flag untouched.
- R11: iir bits 7:6 both equal fifo_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lsr_err | input | 1 | Receiver line error condition (level) |
| rx_ready | input | 1 | Receive data ready condition (level) |
| rx_timeout | input | 1 | Receive timeout condition (level) |
| thr_evt | input | 1 | Transmit holding register became empty (pulse) |
| msr_chg | input | 1 | Modem status change condition (level) |
| xoff_det | input | 1 | Xoff or special character detected (pulse) |
| xon_det | input | 1 | Xon character detected (pulse) |
| flow_chg | input | 1 | Flow-control line change condition (level) |
| ier | input | 6 | Per-source enable bits |
| efr_en | input | 1 | Extended-feature enable |
| fifo_en | input | 1 | FIFOs enabled flag |
| iir_rd | input | 1 | Read strobe of the identification register |
| iir | output | 8 | Identification register value |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two functions can fall in the same cycle: the read acknowledge of transmit-empty and a new empty event. Another such pair is Xoff setting and Xon clearing of the sticky flag. The bench drives both pulses of each pair in one cycle. It then judges the register one edge later, where transmit-empty must still be reported and the Xoff code must still be present. It also reads the register while a higher source masks transmit-empty, and confirms that the flag survives once that source drops.

// File: rtl/uart_irq_pkg.sv
// Shared constants for the interrupt identification encoder.
// Assumes the source order below is the priority order (index 0 highest).
package uart_irq_pkg;
    localparam int IER_W   = 6;
    localparam int N_SRC   = 7;
    localparam int IDX_W   = $clog2(N_SRC);
    localparam int CODE_W  = 6;

    // enable bit positions inside ier
    localparam int IE_RX   = 0;
    localparam int IE_THR  = 1;
    localparam int IE_LSR  = 2;
    localparam int IE_MSR  = 3;
    localparam int IE_XOFF = 4;
    localparam int IE_FLOW = 5;

    // priority slots, 0 = highest
    localparam int P_LSR   = 0;
    localparam int P_RXTO  = 1;
    localparam int P_RXRDY = 2;
    localparam int P_THR   = 3;
    localparam int P_MSR   = 4;
    localparam int P_XOFF  = 5;
    localparam int P_FLOW  = 6;

    localparam logic [CODE_W-1:0] CODE_IDLE = 6'b000001;

    // map a priority slot to its identification code
    function automatic logic [CODE_W-1:0] id_code(input logic [IDX_W-1:0] slot);
        case (slot)
            IDX_W'(P_LSR):   id_code = 6'b000110;
            IDX_W'(P_RXTO):  id_code = 6'b001100;
            IDX_W'(P_RXRDY): id_code = 6'b000100;
            IDX_W'(P_THR):   id_code = 6'b000010;
            IDX_W'(P_MSR):   id_code = 6'b000000;
            IDX_W'(P_XOFF):  id_code = 6'b010000;
            IDX_W'(P_FLOW):  id_code = 6'b100000;
            default:         id_code = CODE_IDLE;
        endcase
    endfunction
endpackage

// File: rtl/uart_irq_flags.sv
// Stored interrupt flags: transmit-empty (set by event, cleared by
// acknowledge) and Xoff/special (set by detect, cleared by Xon).
// Assumes single-cycle pulses; a set in the same cycle as a clear wins.
module uart_irq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic thr_set,
    input  logic thr_ack,
    input  logic xoff_set,
    input  logic xon_clr,
    output logic thr_flag,
    output logic xoff_flag
);
    // update both sticky flags; set has precedence over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_flag  <= 1'b0;
            xoff_flag <= 1'b0;
        end else begin
            thr_flag  <= thr_set  | (thr_flag  & ~thr_ack);
            xoff_flag <= xoff_set | (xoff_flag & ~xon_clr);
        end
    end
endmodule

// File: rtl/uart_irq_prio.sv
// Fixed-priority selector: finds the lowest-index active request.
// Assumes index 0 is the highest priority; purely combinational.
module uart_irq_prio #(
    parameter int N     = 7,
    localparam int IW   = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] slot
);
    logic [N:0]     seen;
    logic [N-1:0]   first;

    assign seen[0] = 1'b0;

    // thermometer of "a higher request exists" and one-hot winner
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign first[i]  = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end

    // encode the one-hot winner into a slot number
    always_comb begin
        slot = '0;
        for (int i = 0; i < N; i++) begin
            if (first[i]) slot = IW'(i);
        end
    end

    assign valid = seen[N];
endmodule

// File: rtl/uart_irq_id.sv
// Interrupt identification encoder for a single-channel UART.
// Gathers gated sources in priority order, selects the winner and forms
// the identification byte. Assumes pulses are one cycle wide and that
// iir_rd is asserted for one cycle per register read.
module uart_irq_id
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lsr_err,
    input  logic             rx_ready,
    input  logic             rx_timeout,
    input  logic             thr_evt,
    input  logic             msr_chg,
    input  logic             xoff_det,
    input  logic             xon_det,
    input  logic             flow_chg,
    input  logic [IER_W-1:0] ier,
    input  logic             efr_en,
    input  logic             fifo_en,
    input  logic             iir_rd,
    output logic [7:0]       iir,
    output logic             irq
);
    logic             thr_flag;
    logic             xoff_flag;
    logic             thr_ack;
    logic [N_SRC-1:0] req;
    logic             any;
    logic [IDX_W-1:0] win;

    uart_irq_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .thr_set   (thr_evt),
        .thr_ack   (thr_ack),
        .xoff_set  (xoff_det),
        .xon_clr   (xon_det),
        .thr_flag  (thr_flag),
        .xoff_flag (xoff_flag)
    );

    // gate each source with its enable, in priority order
    always_comb begin
        req          = '0;
        req[P_LSR]   = lsr_err    & ier[IE_LSR];
        req[P_RXTO]  = rx_timeout & ier[IE_RX];
        req[P_RXRDY] = rx_ready   & ier[IE_RX];
        req[P_THR]   = thr_flag   & ier[IE_THR];
        req[P_MSR]   = msr_chg    & ier[IE_MSR];
        req[P_XOFF]  = xoff_flag  & ier[IE_XOFF] & efr_en;
        req[P_FLOW]  = flow_chg   & ier[IE_FLOW] & efr_en;
    end

    uart_irq_prio #(.N(N_SRC)) u_prio (
        .req   (req),
        .valid (any),
        .slot  (win)
    );

    // acknowledge transmit-empty only when it is the reported cause
    assign thr_ack = iir_rd & any & (win == IDX_W'(P_THR));

    // form the identification byte and the request line
    always_comb begin
        iir[7:6] = {2{fifo_en}};
        iir[5:0] = any ? id_code(win) : CODE_IDLE;
    end

    assign irq = any;
endmodule

// File: rtl/uart_irq_id_chk.sv
// Property checker for uart_irq_id, attached by bind.
// Assumes the port names of the encoder.
module uart_irq_id_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lsr_err,
    input logic       rx_ready,
    input logic       rx_timeout,
    input logic       thr_evt,
    input logic       msr_chg,
    input logic       xoff_det,
    input logic       xon_det,
    input logic       flow_chg,
    input logic [5:0] ier,
    input logic       efr_en,
    input logic       fifo_en,
    input logic       iir_rd,
    input logic [7:0] iir,
    input logic       irq
);
    // R2: request line opposes bit 0
    a_r2_irq_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        irq != iir[0]);

    // R4: an enabled line error always wins
    a_r4_lsr_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_err && ier[2]) |-> iir[5:0] == 6'b000110);

    // R6: extended bits silent without the extended enable
    a_r6_ext_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !efr_en |-> iir[5:4] == 2'b00);

    // R11: top bits track the FIFO flag
    a_r11_fifo_bits: assert property (@(posedge clk) disable iff (!rst_n)
        iir[7:6] == {2{fifo_en}});

    // R8: acknowledged transmit-empty is gone the next cycle
    a_r8_thr_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && iir[3:0] == 4'b0010 && !thr_evt) |=> iir[3:0] != 4'b0010);

    // R9: a new empty event during the read keeps it pending
    a_r9_thr_collide: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && iir[3:0] == 4'b0010 && thr_evt && !lsr_err && !rx_ready
         && !rx_timeout && $stable(ier)) |=> iir[3:0] == 4'b0010);
endmodule

bind uart_irq_id uart_irq_id_chk u_chk (.*);

// File: tb/uart_irq_id_test.sv
module uart_irq_id_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       lsr_err, rx_ready, rx_timeout, thr_evt, msr_chg;
    logic       xoff_det, xon_det, flow_chg, efr_en, fifo_en, iir_rd;
    logic [5:0] ier;
    logic [7:0] iir;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_id uut (
        .clk(clk), .rst_n(rst_n), .lsr_err(lsr_err), .rx_ready(rx_ready),
        .rx_timeout(rx_timeout), .thr_evt(thr_evt), .msr_chg(msr_chg),
        .xoff_det(xoff_det), .xon_det(xon_det), .flow_chg(flow_chg),
        .ier(ier), .efr_en(efr_en), .fifo_en(fifo_en), .iir_rd(iir_rd),
        .iir(iir), .irq(irq)
    );

    // vector: {lsr,rx,to,msr,flow}[20:16] ier[15:10] efr[9] fifo[8] exp[7:0]
    localparam logic [20:0] VEC [NVEC] = '{
        {5'b00000, 6'h3F, 1'b0, 1'b0, 8'h01},  // R2 idle
        {5'b10000, 6'h3F, 1'b0, 1'b0, 8'h06},  // R3 line error
        {5'b11100, 6'h3F, 1'b0, 1'b0, 8'h06},  // R4 error over rx
        {5'b01000, 6'h3F, 1'b0, 1'b0, 8'h04},  // R3 rx ready
        {5'b01100, 6'h3F, 1'b0, 1'b0, 8'h0C},  // R4 timeout over ready
        {5'b00010, 6'h3F, 1'b0, 1'b0, 8'h00},  // R3 modem
        {5'b01010, 6'h3F, 1'b0, 1'b0, 8'h04},  // R4 rx over modem
        {5'b00001, 6'h3F, 1'b1, 1'b0, 8'h20},  // R3 flow change
        {5'b00001, 6'h3F, 1'b0, 1'b0, 8'h01},  // R6 flow gated
        {5'b00000, 6'h3F, 1'b0, 1'b1, 8'hC1},  // R11 fifo bits
        {5'b11000, 6'h3B, 1'b0, 1'b0, 8'h04},  // R5 error disabled
        {5'b00011, 6'h3F, 1'b1, 1'b1, 8'hC0}   // R4 modem over flow
    };

    task automatic chk(input string req, input logic [7:0] exp);
        n_cmp++;
        if (iir !== exp || irq !== ~exp[0]) begin
            n_bad++;
            $display("FAIL %s: iir=%h irq=%b expected iir=%h irq=%b",
                     req, iir, irq, exp, ~exp[0]);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clr_levels();
        {lsr_err, rx_ready, rx_timeout, msr_chg, flow_chg} = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; clr_levels();
        {thr_evt, xoff_det, xon_det, iir_rd} = '0;
        ier = 6'h3F; efr_en = 1'b1; fifo_en = 1'b0;
        step(); step();
        chk("R1 reset", 8'h01);
        rst_n = 1'b1;
        step();
        chk("R1 after release", 8'h01);

        for (int i = 0; i < NVEC; i++) begin
            {lsr_err, rx_ready, rx_timeout, msr_chg, flow_chg} = VEC[i][20:16];
            ier = VEC[i][15:10]; efr_en = VEC[i][9]; fifo_en = VEC[i][8];
            #1;
            chk($sformatf("R3/R4 vector %0d", i), VEC[i][7:0]);
            @(negedge clk);
        end
        clr_levels(); ier = 6'h3F; efr_en = 1'b0; fifo_en = 1'b0;

        // R8 set then acknowledge
        thr_evt = 1'b1; step(); thr_evt = 1'b0;
        chk("R8 thr set", 8'h02);
        iir_rd = 1'b1; step(); iir_rd = 1'b0;
        chk("R8 thr acknowledged", 8'h01);

        // R9 read collides with new empty event
        thr_evt = 1'b1; step();
        iir_rd = 1'b1; step(); iir_rd = 1'b0; thr_evt = 1'b0;
        chk("R9 thr kept", 8'h02);
        step();
        chk("R9 thr still pending", 8'h02);

        // R10 read while masked by line error
        lsr_err = 1'b1; #1;
        chk("R10 error reported", 8'h06);
        iir_rd = 1'b1; step(); iir_rd = 1'b0; lsr_err = 1'b0; #1;
        chk("R10 thr survives", 8'h02);
        iir_rd = 1'b1; step(); iir_rd = 1'b0;

        // R5 disabled transmit-empty kept
        ier = 6'h3D; thr_evt = 1'b1; step(); thr_evt = 1'b0;
        chk("R5 thr disabled", 8'h01);
        ier = 6'h3F; #1;
        chk("R5 thr shows once enabled", 8'h02);
        iir_rd = 1'b1; step(); iir_rd = 1'b0;

        // R7 xoff sticky and R6 gating
        efr_en = 1'b1; xoff_det = 1'b1; step(); xoff_det = 1'b0;
        chk("R7 xoff set", 8'h10);
        step();
        chk("R7 xoff held", 8'h10);
        efr_en = 1'b0; #1;
        chk("R6 xoff gated", 8'h01);
        efr_en = 1'b1; flow_chg = 1'b1; #1;
        chk("R4 xoff over flow", 8'h10);
        flow_chg = 1'b0;
        xon_det = 1'b1; step(); xon_det = 1'b0;
        chk("R7 xon clears", 8'h01);
        xoff_det = 1'b1; xon_det = 1'b1; step();
        xoff_det = 1'b0; xon_det = 1'b0;
        chk("R7 set wins", 8'h10);
        thr_evt = 1'b1; step(); thr_evt = 1'b0;
        chk("R4 thr over xoff", 8'h02);

        // R1 reset with flags set
        rst_n = 1'b0; step(); rst_n = 1'b1; step();
        chk("R1 reset clears flags", 8'h01);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule